// File: doc/BRIEF.md
# Auto power-down conversion sequencer

This block sequences a serial ADC that keeps itself powered down between conversions. It runs on a system clock and watches an active-high conversion strobe that arrives from outside the clock domain. A rising strobe wakes the converter. Power-up is then timed internally. The conversion starts when the strobe has fallen and power-up is complete, whichever of the two happens later. After a fixed conversion interval, the block issues a one-cycle latch pulse and the new result word is loaded into the serial output register. If the strobe is low at that point, the converter powers down again by itself.

The analog front end is replaced by a behavioural stub. The stub takes the word on `stub_data_i` when a conversion starts and returns it at the end of that conversion. The serial shifting itself is not part of this block. `result_o` models the parallel contents of the output shift register, and they change only on a latch.

A strobe that is still high when a result is latched keeps the converter powered and idle. Its next falling edge starts a new conversion at once, with no power-up interval.

Top module: `pd_conv_seq`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `pwr_en_o`, `busy_o` and `latch_o` are 0 and `result_o` is 0.
- R2: While powered down, a strobe first sampled high at clock edge n sets `pwr_en_o` and `busy_o` from edge n+2. There are two synchroniser flops and one edge-detect stage on the way.
- R3: If the synchronised strobe is still high in the last of the `PWRUP_CYC` power-up cycles, the conversion starts at edge f+2, where f is the first edge that samples the strobe low.
- R4: If the strobe has fallen before power-up ends, power-up still runs its full `PWRUP_CYC` cycles, and the conversion starts on the next edge.
- R5: A conversion lasts `CONV_CYC` cycles. `latch_o` is high for exactly its last cycle. `busy_o` stays high from the start of power-up through that cycle and goes low right after it.
- R6: At the edge that ends the latch cycle, `result_o` takes the `stub_data_i` value that was sampled when the conversion started.
- R7: If the strobe is low in the latch cycle, `pwr_en_o` is 0 from the next edge onwards.
- R8: In every other cycle, including the whole of power-up and conversion, `result_o` keeps the previous result.
- R9: A strobe rising edge that arrives during power-up or conversion is ignored. It changes neither the latch timing nor the result, and it starts no further cycle.
- R10: If the strobe is high in the latch cycle, `pwr_en_o` stays 1 and `busy_o` goes to 0. The next strobe falling edge then starts a conversion at edge f+2 with no power-up interval, and `busy_o` is high again during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Conversion strobe, asynchronous, active high |
| stub_data_i | input | DATA_W | Value returned by the converter stub |
| pwr_en_o | output | 1 | Converter power enable |
| busy_o | output | 1 | Power-up or conversion in progress |
| latch_o | output | 1 | One-cycle pulse that loads the result word |
| result_o | output | DATA_W | Contents of the serial output register |

## Verification
Take c as the last cycle before the strobe goes high, and d as the last cycle before it goes low. Power and busy are due from cycle c+3. The conversion starts at max(c+PWRUP_CYC, d)+3. The latch pulse is due in the cycle CONV_CYC-1 after that start, and the new result and the power-down are due one cycle after the latch. The driver computes each latch cycle and its data from these formulas and pushes them into a queue. A monitor samples on the falling clock edge. On every latch pulse it pops the next entry, compares the cycle and checks that the old result is still present. On the following cycle it checks the new result. Any latch that arrives with an empty queue is reported as a failure.

// File: rtl/pdcs_pkg.sv
package pdcs_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_PWRUP,
    ST_WAIT_FALL,
    ST_CONV,
    ST_HOLD
  } pdcs_state_e;
endpackage

// File: rtl/pdcs_sync_edge.sv
module pdcs_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/pdcs_timer.sv
module pdcs_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R5
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/pdcs_fsm.sv
module pdcs_fsm
  import pdcs_pkg::*;
#(
  parameter int PWRUP_CYC = 125,
  parameter int CONV_CYC  = 250,
  parameter int TW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          done_i,
  output logic          load_o,
  output logic [TW-1:0] load_val_o,
  output logic          conv_start_o,
  output logic          pwr_en_o,
  output logic          busy_o,
  output logic          latch_o
);
  localparam logic [TW-1:0] PwrupLoad = TW'(PWRUP_CYC - 1);
  localparam logic [TW-1:0] ConvLoad  = TW'(CONV_CYC - 1);

  pdcs_state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    load_o       = 1'b0;
    load_val_o   = ConvLoad;
    conv_start_o = 1'b0;
    unique case (state_q)
      ST_OFF: if (rise_i) begin
        state_d    = ST_PWRUP;
        load_o     = 1'b1;
        load_val_o = PwrupLoad;
      end
      ST_PWRUP: if (done_i) begin
        if (lvl_i) state_d = ST_WAIT_FALL;
        else begin
          state_d      = ST_CONV;
          load_o       = 1'b1;
          conv_start_o = 1'b1;
        end
      end
      ST_WAIT_FALL, ST_HOLD: if (fall_i) begin
        state_d      = ST_CONV;
        load_o       = 1'b1;
        conv_start_o = 1'b1;
      end
      ST_CONV: if (done_i) state_d = lvl_i ? ST_HOLD : ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign pwr_en_o = (state_q != ST_OFF);
  assign busy_o   = (state_q == ST_PWRUP) || (state_q == ST_WAIT_FALL) || (state_q == ST_CONV);
  assign latch_o  = (state_q == ST_CONV) && done_i;

  // R2
  pwrup_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_en_o && rise_i) |=> (pwr_en_o && busy_o));
  // R7
  auto_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o && !lvl_i) |=> !pwr_en_o);
  // R10
  hold_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o && lvl_i) |=> (pwr_en_o && !busy_o));
  // R9
  busy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !latch_o) |=> busy_o);
  // R5
  latch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> busy_o);
endmodule

// File: rtl/pdcs_result.sv
module pdcs_result #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              latch_i,
  input  logic [DATA_W-1:0] stub_data_i,
  output logic [DATA_W-1:0] result_o
);
  // behavioural converter stub: value frozen at conversion start
  logic [DATA_W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q    <= '0;
      result_o <= '0;
    end else begin
      if (conv_start_i) cap_q    <= stub_data_i;
      if (latch_i)      result_o <= cap_q;
    end
  end

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(result_o));
  // R6
  new_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (result_o == $past(cap_q)));
endmodule

// File: rtl/pd_conv_seq.sv
module pd_conv_seq #(
  parameter int PWRUP_CYC = 125,
  parameter int CONV_CYC  = 250,
  parameter int DATA_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] stub_data_i,
  output logic              pwr_en_o,
  output logic              busy_o,
  output logic              latch_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int MaxCyc = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int TW     = $clog2(MaxCyc + 1);

  logic          lvl, rise, fall, done, load, conv_start;
  logic [TW-1:0] load_val;

  pdcs_sync_edge u_sync (
    .clk_i, .rst_ni, .async_i(strobe_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pdcs_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .done_o(done)
  );

  pdcs_fsm #(.PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC), .TW(TW)) u_fsm (
    .clk_i, .rst_ni, .lvl_i(lvl), .rise_i(rise), .fall_i(fall), .done_i(done),
    .load_o(load), .load_val_o(load_val), .conv_start_o(conv_start),
    .pwr_en_o, .busy_o, .latch_o
  );

  pdcs_result #(.DATA_W(DATA_W)) u_res (
    .clk_i, .rst_ni, .conv_start_i(conv_start), .latch_i(latch_o),
    .stub_data_i, .result_o
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) $rose(rst_ni) |-> (!pwr_en_o && !busy_o && !latch_o));
endmodule

// File: tb/pd_conv_seq_tb.sv
module pd_conv_seq_tb;
  localparam int P = 125;
  localparam int C = 250;
  localparam int W = 10;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0;
  logic [W-1:0] stub = '0;
  logic pwr_en, busy, latch;
  logic [W-1:0] result;

  int cyc = 0, errors = 0, checks = 0;
  bit finished = 0;

  typedef struct { int cyc; logic [W-1:0] data; string tag; } exp_t;
  exp_t q[$];
  logic [W-1:0] model_res = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pd_conv_seq #(.PWRUP_CYC(P), .CONV_CYC(C), .DATA_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .stub_data_i(stub),
    .pwr_en_o(pwr_en), .busy_o(busy), .latch_o(latch), .result_o(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: pops on every latch pulse
  bit pend = 0;
  exp_t cur;
  always @(negedge clk) if (rst_n && !finished) begin
    if (pend) begin
      chk(result == cur.data, "R6 new result", int'(result), int'(cur.data));
      model_res = cur.data;
      pend = 0;
    end
    if (latch) begin
      if (q.size() == 0) chk(0, "R9 unexpected latch", cyc, -1);
      else begin
        cur = q.pop_front();
        chk(cyc == cur.cyc, {cur.tag, " latch cycle"}, cyc, cur.cyc);
        chk(result == model_res, "R8 old result kept", int'(result), int'(model_res));
        pend = 1;
      end
    end
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // strobe high for hi cycles then low; strobe low at latch
  task automatic op(input logic [W-1:0] d, input int hi, input string tag);
    int c, dd, st;
    c = cyc; strobe = 1'b1; stub = d;
    for (int i = 1; i <= hi; i++) begin
      @(negedge clk);
      if (i == 2) chk(!pwr_en, "R2 pwr before", pwr_en, 0);
      if (i == 3) chk(pwr_en && busy, "R2 pwr+busy", {pwr_en, busy}, 3);
    end
    dd = cyc; strobe = 1'b0;
    st = mx(c + P, dd) + 3;
    q.push_back('{st + C - 1, d, tag});
    wait_to(st - 1);
    chk(pwr_en && busy, {tag, " powered before conv"}, {pwr_en, busy}, 3);
    wait_to(st + C);
    chk(!busy && !pwr_en, "R7 R5 off after latch", {pwr_en, busy}, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int c, d, st, l1;
    repeat (3) @(negedge clk);
    chk(!pwr_en && !busy && !latch && result == 0, "R1 in reset", {pwr_en, busy, latch}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pwr_en && !busy && !latch && result == 0, "R1 after reset", {pwr_en, busy, latch}, 0);

    op(10'h2A5, 3, "R4");          // strobe falls during power-up
    op(10'h15A, P + 40, "R3");     // strobe held past power-up
    op(10'h3FF, P, "R3");          // fall exactly at the boundary

    // R9: extra rise during power-up, level low at its end
    c = cyc; strobe = 1'b1; stub = 10'h0C3;
    repeat (4) @(negedge clk); strobe = 1'b0;
    repeat (20) @(negedge clk); strobe = 1'b1;
    repeat (10) @(negedge clk); strobe = 1'b0;
    st = c + P + 3;
    q.push_back('{st + C - 1, 10'h0C3, "R9 rise in power-up"});
    wait_to(st + C);
    chk(!pwr_en, "R9 R7 off", pwr_en, 0);
    repeat (30) @(negedge clk);
    chk(!pwr_en && !busy && q.size() == 0, "R9 no new cycle", {pwr_en, busy}, 0);

    // R10: rise during conversion (ignored), held through latch -> hold
    c = cyc; strobe = 1'b1; stub = 10'h111;
    repeat (P + 10) @(negedge clk);
    d = cyc; strobe = 1'b0;
    st = d + 3; l1 = st + C - 1;
    q.push_back('{l1, 10'h111, "R9 rise in conversion"});
    wait_to(st + 50); strobe = 1'b1;
    @(negedge clk); stub = 10'h222;
    wait_to(l1 + 1);
    chk(pwr_en && !busy, "R10 hold powered idle", {pwr_en, busy}, 2);
    repeat (20) @(negedge clk);
    chk(pwr_en && !busy && q.size() == 0, "R10 hold stays", {pwr_en, busy}, 2);
    d = cyc; strobe = 1'b0;
    st = d + 3;
    q.push_back('{st + C - 1, 10'h222, "R10 no power-up"});
    wait_to(st);
    chk(busy, "R10 busy in conv", busy, 1);
    wait_to(st + C);
    chk(!pwr_en && !busy, "R10 R7 off", {pwr_en, busy}, 0);
    repeat (5) @(negedge clk);
    chk(q.size() == 0 && !pend, "R5 all latches seen", q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule